// File: doc/BRIEF.md
# Bidirectional Universal Bus Transceiver Register

This block moves 17-bit words between an A bus and a B bus. Each direction has its own storage cell, and each cell takes four controls: an active-low output enable, a latch enable, a path clock and an active-low clock enable. With these controls a direction runs in one of four modes. It can be transparent, where the output follows the input. It can be latched, where the output holds. It can be clocked, where the input is captured on a rising path clock. It can be clock-enabled, where rising edges are ignored while the enable is inactive. Both directions use the same kind of cell, and the two cells share no controls.

The block sits in a synchronous fabric that runs from a system clock `clk`. The path clocks `ab_clk` and `ba_clk` are treated as level signals that are synchronous to `clk`. A rising path-clock edge is detected on the first `clk` edge that sees the new high level, and the word is captured on that same edge. The data on each tri-state output is modelled as a value plus a drive flag. The block also forwards two clocks. `ab_clk` is copied to `ab_clk_copy`, and the separate input `rclk_in` is copied to `rclk_out`.

Top module: `ubt_transceiver`

## Requirements
- R1: The two directions are independent. Changing `ab_*` controls or `a_in` never alters `a_out`, and changing `ba_*` controls or `b_in` never alters `b_out`.
- R2: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle. The value present at a `clk` rising edge is stored.
- R3: While `ab_le` is 0, `ab_ce_n` is 0 and `ab_clk` stays at either level, `b_out` holds the stored word no matter how `a_in` changes.
- R4: While `ab_le` is 0 and `ab_ce_n` is 0, a rising `ab_clk` (0 at the previous `clk` edge, 1 at this one) stores `a_in`. `b_out` shows the new word after that `clk` edge.
- R5: While `ab_le` is 0 and `ab_ce_n` is 1, rising `ab_clk` edges are ignored and `b_out` keeps the stored word.
- R6: `ab_le` = 1 overrides the clock. `b_out` tracks `a_in` whatever `ab_clk` and `ab_ce_n` do.
- R7: `b_drv` is 1 exactly when `ab_oe_n` is 0. The cell keeps capturing while the output is disabled, so the word captured during that time appears once the output is enabled again.
- R8: The B-to-A path behaves the same way: `ba_le` makes it transparent, a rising `ba_clk` with `ba_ce_n` = 0 captures, and `a_drv` = !`ba_oe_n`.
- R9: `ab_clk_copy` equals `ab_clk` and `rclk_out` equals `rclk_in`, with no register delay.
- R10: An asynchronous low `rst_n` clears both stored words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 17 | Word arriving on the A bus |
| a_out | output | 17 | Word driven toward the A bus |
| a_drv | output | 1 | A-side drive flag (0 = high impedance) |
| b_in | input | 17 | Word arriving on the B bus |
| b_out | output | 17 | Word driven toward the B bus |
| b_drv | output | 1 | B-side drive flag (0 = high impedance) |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_clk | input | 1 | A-to-B path clock |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_clk | input | 1 | B-to-A path clock |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| rclk_in | input | 1 | Incoming clock to forward |
| ab_clk_copy | output | 1 | Buffered copy of ab_clk |
| rclk_out | output | 1 | Buffered copy of rclk_in |

## Verification
A path-clock rising edge and a latch-enable level can fall on the same `clk` edge, and the cell must then take the transparent branch. The bench provokes this by raising `ab_clk` while `ab_le` is 1 and `ab_ce_n` is 1. It then checks that `b_out` follows `a_in` and is not gated by the enable. A second case holds `ab_clk` high across a `clk` edge while `ab_le` falls. That checks that the level alone, with no new edge, does not recapture.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
    localparam int unsigned WORD_W = 17;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              pclk_seen;
    } cell_state_t;
endpackage

// File: rtl/ubt_cell.sv
module ubt_cell #(
    parameter int unsigned W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         le,
    input  logic         pclk,
    input  logic         ce_n,
    input  logic         oe_n,
    output logic [W-1:0] dout,
    output logic         drv
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         pclk_seen;
    } st_t;

    st_t st_d, st_q;
    logic rise;

    always_comb begin
        st_d           = st_q;
        st_d.pclk_seen = pclk;
        rise           = pclk && !st_q.pclk_seen;
        if (le) begin
            st_d.word = din;
        end else if (!ce_n && rise) begin
            st_d.word = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = le ? din : st_q.word;
    assign drv  = !oe_n;

    // R2
    transparent_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> st_q.word == $past(din));

    // R3
    hold_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !(pclk && !st_q.pclk_seen)) |=> $stable(st_q.word));

    // R4
    edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !ce_n && pclk && !st_q.pclk_seen) |=> st_q.word == $past(din));

    // R5
    gated_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && ce_n) |=> $stable(st_q.word));
endmodule

// File: rtl/ubt_clkfwd.sv
module ubt_clkfwd #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] ck_in,
    output logic [N-1:0] ck_out
);
    for (genvar i = 0; i < N; i++) begin : g_buf
        assign ck_out[i] = ck_in[i];
    end
endmodule

// File: rtl/ubt_transceiver.sv
module ubt_transceiver
    import ubt_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_drv,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_clk,
    input  logic         ab_ce_n,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_clk,
    input  logic         ba_ce_n,
    input  logic         rclk_in,
    output logic         ab_clk_copy,
    output logic         rclk_out
);
    localparam int unsigned NDIR = 2;

    logic [NDIR-1:0][W-1:0] din_v, dout_v;
    logic [NDIR-1:0]        le_v, pclk_v, ce_v, oe_v, drv_v;

    assign din_v  = {b_in,    a_in};
    assign le_v   = {ba_le,   ab_le};
    assign pclk_v = {ba_clk,  ab_clk};
    assign ce_v   = {ba_ce_n, ab_ce_n};
    assign oe_v   = {ba_oe_n, ab_oe_n};

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        ubt_cell #(.W(W)) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (din_v[d]),
            .le   (le_v[d]),
            .pclk (pclk_v[d]),
            .ce_n (ce_v[d]),
            .oe_n (oe_v[d]),
            .dout (dout_v[d]),
            .drv  (drv_v[d])
        );
    end

    assign b_out = dout_v[0];
    assign b_drv = drv_v[0];
    assign a_out = dout_v[1];
    assign a_drv = drv_v[1];

    logic [1:0] ck_fw;
    ubt_clkfwd #(.N(2)) u_clkfwd (
        .ck_in ({rclk_in, ab_clk}),
        .ck_out(ck_fw)
    );
    assign ab_clk_copy = ck_fw[0];
    assign rclk_out    = ck_fw[1];
endmodule

// File: tb/ubt_transceiver_test.sv
`timescale 1ns/1ps
module ubt_transceiver_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] a_in = '0, b_in = '0;
    logic [16:0] a_out, b_out;
    logic        a_drv, b_drv;
    logic        ab_oe_n = 1'b0, ab_le = 1'b0, ab_clk = 1'b0, ab_ce_n = 1'b0;
    logic        ba_oe_n = 1'b0, ba_le = 1'b0, ba_clk = 1'b0, ba_ce_n = 1'b0;
    logic        rclk_in = 1'b0;
    logic        ab_clk_copy, rclk_out;
    int          n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    ubt_transceiver uut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_ce_n(ab_ce_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_ce_n(ba_ce_n),
        .rclk_in(rclk_in), .ab_clk_copy(ab_clk_copy), .rclk_out(rclk_out)
    );

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 b_out after reset", b_out, 17'h0);
        check("R10 a_out after reset", a_out, 17'h0);
        check("R7 b_drv with oe_n=0", {16'h0, b_drv}, 17'h1);
    endtask

    task automatic t_transparent_hold();
        ab_le = 1'b1; a_in = 17'h1A5A5; #1;
        check("R2 same-cycle follow", b_out, 17'h1A5A5);
        a_in = 17'h0F0F0; #1;
        check("R2 follow change", b_out, 17'h0F0F0);
        step();
        ab_le = 1'b0; a_in = 17'h12345; #1;
        check("R3 hold after le falls", b_out, 17'h0F0F0);
        step(); step();
        a_in = 17'h00001; step();
        check("R3 hold clk low", b_out, 17'h0F0F0);
    endtask

    task automatic t_clocked();
        ab_ce_n = 1'b0; a_in = 17'h15555; ab_clk = 1'b1;
        step();
        check("R4 capture on rise", b_out, 17'h15555);
        a_in = 17'h0AAAA; step(); step();
        check("R3 hold clk high", b_out, 17'h15555);
        ab_clk = 1'b0; step();
        check("R3 falling edge ignored", b_out, 17'h15555);
    endtask

    task automatic t_ce_block();
        ab_ce_n = 1'b1; a_in = 17'h1FFFF; ab_clk = 1'b1; step();
        ab_clk = 1'b0; step();
        check("R5 edge ignored ce_n=1", b_out, 17'h15555);
    endtask

    task automatic t_priority();
        ab_le = 1'b1; ab_ce_n = 1'b1; a_in = 17'h03C3C; ab_clk = 1'b1; #1;
        check("R6 le over clock", b_out, 17'h03C3C);
        step();
        ab_clk = 1'b0; a_in = 17'h1C3C3; #1;
        check("R6 tracks input", b_out, 17'h1C3C3);
        step();
        ab_le = 1'b0; ab_clk = 1'b1; ab_ce_n = 1'b0; a_in = 17'h00077;
        step();
        ab_le = 1'b0; a_in = 17'h00099; step();
        check("R4 edge with le falling captures", b_out, 17'h00077);
        ab_clk = 1'b0; step();
    endtask

    task automatic t_oe();
        ab_oe_n = 1'b1; #1;
        check("R7 b_drv off", {16'h0, b_drv}, 17'h0);
        a_in = 17'h0BEEF; ab_clk = 1'b1; step();
        ab_clk = 1'b0; a_in = 17'h0; step();
        ab_oe_n = 1'b0; #1;
        check("R7 b_drv on", {16'h0, b_drv}, 17'h1);
        check("R7 captured while disabled", b_out, 17'h0BEEF);
    endtask

    task automatic t_ba();
        ba_le = 1'b1; b_in = 17'h13579; #1;
        check("R8 ba transparent", a_out, 17'h13579);
        step();
        ba_le = 1'b0; ba_ce_n = 1'b0; b_in = 17'h02468; ba_clk = 1'b1; step();
        check("R8 ba capture", a_out, 17'h02468);
        ba_clk = 1'b0; ba_ce_n = 1'b1; b_in = 17'h1111; step();
        ba_clk = 1'b1; step();
        check("R8 ba ce_n blocks", a_out, 17'h02468);
        ba_clk = 1'b0;
        ab_le = 1'b1; a_in = 17'h1DEAD; ab_clk = 1'b1; step();
        check("R1 a_out untouched by ab side", a_out, 17'h02468);
        ab_le = 1'b0; ab_clk = 1'b0; step();
        check("R1 b_out untouched by ba side", b_out, 17'h1DEAD);
        ba_oe_n = 1'b1; #1;
        check("R8 a_drv off", {16'h0, a_drv}, 17'h0);
        ba_oe_n = 1'b0;
    endtask

    task automatic t_clocks();
        ab_clk = 1'b1; rclk_in = 1'b0; #1;
        check("R9 ab_clk copy high", {16'h0, ab_clk_copy}, 17'h1);
        check("R9 rclk low", {16'h0, rclk_out}, 17'h0);
        ab_clk = 1'b0; rclk_in = 1'b1; #1;
        check("R9 ab_clk copy low", {16'h0, ab_clk_copy}, 17'h0);
        check("R9 rclk high", {16'h0, rclk_out}, 17'h1);
        ab_le = 1'b1; step(); ab_le = 1'b0;
    endtask

    task automatic t_reset_again();
        step();
        rst_n = 1'b0; #1;
        check("R10 async clear b", b_out, 17'h0);
        check("R10 async clear a", a_out, 17'h0);
        step(); rst_n = 1'b1; step();
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_transparent_hold();
        t_clocked();
        t_ce_block();
        t_priority();
        t_oe();
        t_ba();
        t_clocks();
        t_reset_again();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule